// File: doc/BRIEF.md
# Bit-Serial Q1.19 Fixed-Point Multiplier

This block is the multiply stage of one arithmetic stream in a machine where several such streams run side by side. It talks to its neighbours only over one-bit serial lines: each 20-bit operand arrives on its own data line over a fixed 20-clock frame. The fractional product leaves on a single result line in another 20-clock frame. Division and logic operations belong to other units, so this block only multiplies.

Both operands and the result are two's complement Q1.19 values: one sign/integer bit followed by 19 fraction bits. A capture is opened by raising the frame strobe and the start signal together. That cycle carries bit 0 of both operands, and the remaining bits follow least-significant first on the next 19 clocks. The full 40-bit product is shifted arithmetically right by 19 and cut down to 20 bits. The result goes out on the clock after the last operand bit, and the result-valid strobe is high for each of its 20 bits. The next operand pair may arrive while a result is still leaving.

Top module: `serial_fx_mult`

## Requirements
- R1: While reset is high and on the first clock after it falls, `res_valid` and `res_sd` are both 0.
- R2: A capture starts on a cycle where both `frame_in` and `start` are 1 while the block is idle. That cycle carries bit 0 of operand A on `op_a_sd` and of operand B on `op_b_sd`, and bits 1 to 19 follow on the next 19 clocks, least-significant bit first.
- R3: While idle, `frame_in` without `start`, or `start` without `frame_in`, starts no capture and produces no result frame.
- R4: During a capture, `frame_in` and `start` are ignored. The frame keeps its 20-bit timing and its result is unchanged.
- R5: The result is bits 38..19 of the signed 40-bit product A*B, which is the product shifted arithmetically right by 19 and truncated to 20 bits, in two's complement Q1.19.
- R6: -1.0 times -1.0 (0x80000 times 0x80000) wraps to 0x80000.
- R7: Result bit 0 appears on `res_sd` in the clock after the last operand bit is sampled. The other bits follow least-significant first, and `res_valid` is 1 for exactly those 20 clocks of a lone frame.
- R8: A new capture may start on the clock right after the last bit of the previous one. Back-to-back results come out with `res_valid` held continuously and each word correct.
- R9: Truncation rounds toward minus infinity. For example, 0x00001 times 0xFFFFF gives 0xFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_in | input | 1 | Word-frame strobe, marks bit 0 of an operand frame |
| start | input | 1 | Qualifies a frame as a multiply request |
| op_a_sd | input | 1 | Serial operand A, LSB first |
| op_b_sd | input | 1 | Serial operand B, LSB first |
| res_sd | output | 1 | Serial product, LSB first |
| res_valid | output | 1 | High for each of the 20 result bits |

## Verification
The bench sends the sign corners: -1.0 squared, where a design that saturated or widened would return 0x7FFFF or lose the sign, and a one-LSB negative product, where rounding toward zero would give 0 in place of 0xFFFFF. It raises a stray strobe halfway through a frame to show that a design which restarted its bit counter would emit a shifted or extra word. It also sends lone strobes between frames, which a design that misread the qualifier would turn into phantom results. Back-to-back frames, with no idle cycle between them, would expose an output register that is still busy and so drops or overlaps a word. Every word is also checked for its exact start cycle, so an extra or missing pipeline stage shows up.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  localparam int unsigned SFM_WORD_W = 20;
  localparam int unsigned SFM_FRAC_W = 19;

  typedef enum logic {
    CAP_IDLE = 1'b0,
    CAP_RUN  = 1'b1
  } cap_state_t;
endpackage

// File: rtl/sfm_frame_ctrl.sv
module sfm_frame_ctrl
  import sfm_pkg::*;
#(
  parameter int unsigned WORD_W = SFM_WORD_W
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_in,
  input  logic start,
  output logic shift_en,
  output logic last_bit
);
  localparam int unsigned CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  cap_state_t    state;
  logic [CW-1:0] cnt;
  logic          kick;

  assign kick     = (state == CAP_IDLE) && frame_in && start;
  assign shift_en = kick || (state == CAP_RUN);
  assign last_bit = (state == CAP_RUN) && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CAP_IDLE;
      cnt   <= '0;
    end else if (kick) begin
      state <= CAP_RUN;
      cnt   <= CW'(1);
    end else if (state == CAP_RUN) begin
      if (cnt == LAST) begin
        state <= CAP_IDLE;
        cnt   <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // Bit counter stays inside the frame while capturing.
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (state == CAP_RUN) |-> (cnt != '0 && cnt <= LAST));

  // Strobes seen mid-frame do not disturb the count.
  assert_midframe_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (state == CAP_RUN && cnt != LAST) |=> (state == CAP_RUN && cnt == $past(cnt) + CW'(1)));

  // Idle with an unqualified strobe stays idle.
  assert_lone_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    (state == CAP_IDLE && !(frame_in && start)) |=> (state == CAP_IDLE));
endmodule

// File: rtl/sfm_deser.sv
module sfm_deser
  import sfm_pkg::*;
#(
  parameter int unsigned WORD_W = SFM_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              sd,
  output logic [WORD_W-1:0] word_now
);
  logic [WORD_W-1:0] sr;

  // Incoming bit enters at the top; after WORD_W shifts bit 0 sits at the bottom.
  assign word_now = {sd, sr[WORD_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst)           sr <= '0;
    else if (shift_en) sr <= word_now;
  end
endmodule

// File: rtl/sfm_fx_mul.sv
module sfm_fx_mul
  import sfm_pkg::*;
#(
  parameter int unsigned WORD_W = SFM_WORD_W,
  parameter int unsigned FRAC_W = SFM_FRAC_W
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] prod
);
  localparam int unsigned PW = 2 * WORD_W;

  logic signed [PW-1:0] a_x, b_x, full;

  assign a_x  = $signed({{WORD_W{a[WORD_W-1]}}, a});
  assign b_x  = $signed({{WORD_W{b[WORD_W-1]}}, b});
  assign full = a_x * b_x;
  assign prod = WORD_W'(full >>> FRAC_W);
endmodule

// File: rtl/sfm_ser.sv
module sfm_ser
  import sfm_pkg::*;
#(
  parameter int unsigned WORD_W = SFM_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic              res_sd,
  output logic              res_valid
);
  localparam int unsigned CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [WORD_W-1:0] sh;
  logic [CW-1:0]     left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      left      <= '0;
      res_sd    <= 1'b0;
      res_valid <= 1'b0;
    end else if (load) begin
      res_sd    <= word[0];
      sh        <= word >> 1;
      left      <= LAST;
      res_valid <= 1'b1;
    end else if (left != '0) begin
      res_sd    <= sh[0];
      sh        <= sh >> 1;
      left      <= left - CW'(1);
      res_valid <= 1'b1;
    end else begin
      res_sd    <= 1'b0;
      res_valid <= 1'b0;
    end
  end

  assert_load_opens_frame_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> (res_valid && left == LAST));

  assert_frame_closes_R7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && left == '0 && !load) |=> !res_valid);

  // A new word only lands when the previous frame is on its final bit.
  assert_no_truncated_frame_R8: assert property (@(posedge clk) disable iff (rst)
    (load && res_valid) |-> (left == '0));
endmodule

// File: rtl/serial_fx_mult.sv
module serial_fx_mult
  import sfm_pkg::*;
#(
  parameter int unsigned WORD_W = SFM_WORD_W,
  parameter int unsigned FRAC_W = SFM_FRAC_W
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_in,
  input  logic start,
  input  logic op_a_sd,
  input  logic op_b_sd,
  output logic res_sd,
  output logic res_valid
);
  localparam int unsigned N_OPS = 2;

  logic              shift_en, last_bit;
  logic [N_OPS-1:0]  sd_in;
  logic [WORD_W-1:0] op_word [N_OPS];
  logic [WORD_W-1:0] product;

  assign sd_in = {op_b_sd, op_a_sd};

  sfm_frame_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .frame_in (frame_in),
    .start    (start),
    .shift_en (shift_en),
    .last_bit (last_bit)
  );

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    sfm_deser #(.WORD_W(WORD_W)) u_deser (
      .clk      (clk),
      .rst      (rst),
      .shift_en (shift_en),
      .sd       (sd_in[g]),
      .word_now (op_word[g])
    );
  end

  sfm_fx_mul #(.WORD_W(WORD_W), .FRAC_W(FRAC_W)) u_mul (
    .a    (op_word[0]),
    .b    (op_word[1]),
    .prod (product)
  );

  sfm_ser #(.WORD_W(WORD_W)) u_ser (
    .clk       (clk),
    .rst       (rst),
    .load      (last_bit),
    .word      (product),
    .res_sd    (res_sd),
    .res_valid (res_valid)
  );

  assert_result_next_clock_R7: assert property (@(posedge clk) disable iff (rst)
    last_bit |=> res_valid);
endmodule

// File: tb/tb_serial_fx_mult.sv
module tb_serial_fx_mult;
  localparam int W = 20;
  localparam int F = 19;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_in = 1'b0, start = 1'b0, op_a_sd = 1'b0, op_b_sd = 1'b0;
  logic res_sd, res_valid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string ctx = "R5";

  typedef struct {
    logic [W-1:0] val;
    int           at;
    string        tag;
  } exp_t;
  exp_t exp_q[$];

  serial_fx_mult dut (
    .clk(clk), .rst(rst), .frame_in(frame_in), .start(start),
    .op_a_sd(op_a_sd), .op_b_sd(op_b_sd), .res_sd(res_sd), .res_valid(res_valid)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  function automatic logic [W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b);
    logic signed [2*W-1:0] p;
    p = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
    return W'(p >>> F);
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Monitor: assemble result words at the falling edge.
  logic [W-1:0] rx;
  int nbits = 0;
  int rx_at = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (res_valid) begin
        if (nbits == 0) rx_at = cyc;
        rx[nbits] = res_sd;
        nbits++;
        if (nbits == W) begin
          nbits = 0;
          if (exp_q.size() == 0) begin
            chk(0, {ctx, " unexpected result frame"}, int'(rx), 0);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(rx == e.val, {e.tag, " product"}, int'(rx), int'(e.val));
            chk(rx_at == e.at, "R7 first result cycle", rx_at, e.at);
          end
        end
      end else if (nbits != 0) begin
        chk(0, "R7 frame shorter than 20", nbits, W);
        nbits = 0;
      end
    end
  end

  task automatic send(logic [W-1:0] a, logic [W-1:0] b, string tag, bit mid_strobe);
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      frame_in = (i == 0) || (mid_strobe && i == 7);
      start    = (i == 0) || (mid_strobe && i == 7);
      op_a_sd  = a[i];
      op_b_sd  = b[i];
      if (i == 0) exp_q.push_back('{ref_mul(a, b), cyc + W, tag});
    end
  endtask

  task automatic idle(int n, bit noise);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      op_a_sd  = noise ? 1'($urandom) : 1'b0;
      op_b_sd  = noise ? 1'($urandom) : 1'b0;
      frame_in = 1'b0;
      start    = 1'b0;
      if (noise) begin
        if ($urandom_range(1, 0) == 0) frame_in = 1'($urandom);
        else                           start    = 1'($urandom);
      end
    end
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(!res_valid && !res_sd, "R1 outputs in reset", {res_valid, res_sd}, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(!res_valid && !res_sd, "R1 outputs after reset", {res_valid, res_sd}, 0);

    // Directed corners
    send(20'h40000, 20'h40000, "R5 half*half", 0);
    idle(2, 0);
    send(20'h80000, 20'h80000, "R6 minus one squared", 0);
    idle(1, 0);
    send(20'h00001, 20'hFFFFF, "R9 floor of tiny negative", 0);
    send(20'h7FFFF, 20'h7FFFF, "R8 back-to-back max", 0);
    send(20'h80000, 20'h40000, "R8 back-to-back neg half", 0);
    idle(25, 0);

    // Lone strobes while idle must not open a frame
    ctx = "R3";
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      frame_in = k[0]; start = !k[0]; op_a_sd = 1'b1; op_b_sd = 1'b1;
    end
    idle(30, 0);
    chk(exp_q.size() == 0, "R3 no phantom frame", exp_q.size(), 0);

    // Strobe mid-frame
    ctx = "R4";
    send(20'h12345, 20'hABCDE, "R4 mid-frame strobe", 1);
    idle(25, 0);
    chk(exp_q.size() == 0, "R4 single frame only", exp_q.size(), 0);

    // Random traffic with idle noise
    ctx = "R2";
    for (int k = 0; k < 150; k++) begin
      send(20'($urandom), 20'($urandom), "R2 random product", 0);
      if ($urandom_range(2, 0) != 0) idle($urandom_range(4, 1), 1);
    end
    idle(30, 0);
    chk(exp_q.size() == 0, "R8 all results delivered", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule